// File: doc/BRIEF.md
# Delayed-Execution Load-Use Interlock

This block decides, for an in-order pipeline with the stages ID, E1, E2 and E3, whether the instruction waiting in ID may enter E1. For each operand of the instruction that reaches E1, it also picks where that operand comes from. The block does this from register tags alone. The register file, the ALU datapath and the data cache sit outside it. Only the source and destination numbers of each instruction, its kind and its valid flag pass through the block.

ALU execution is delayed by one stage in this pipeline. An ALU instruction latches its operands at the end of E1 and computes in E2, so its result exists at the end of E2. A load returns its data only at the end of E3. Because the consumer's operand capture is moved to E1, a load followed at once by a dependent ALU instruction costs a single bubble. The load data then goes straight from E3 into the consumer's E1 capture. An address base is different: loads and stores form their address early in E1, so that base operand must already sit in a pipeline register when the consumer enters E1. An ALU result feeding such a base therefore needs one bubble, and the value is then taken from the producer's E3 register.

Issue uses a valid/ready handshake. An instruction enters E1 on a clock edge where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the issue stage is stalled. The source must then hold every instruction field stable until the instruction is accepted. `in_ready` depends only on the fields presented in that cycle and on instructions already in flight. It never depends on a later cycle. E1 to E3 always advance: no back-pressure exists past issue.

Top module: `dlyx_interlock`

## Requirements
- R1: A load writing register r, followed on the next accepted slot by an instruction that reads r as a late operand (any ALU operand, or the second operand of a load or store), stalls exactly one cycle. In E1 that operand then selects code 3, load data from E3.
- R2: An ALU instruction writing r, followed at once by an instruction that reads r as a late operand, does not stall. The operand selects code 1, the ALU result leaving E2.
- R3: An ALU instruction writing r, followed at once by a load or store whose first (address base) operand is r, stalls exactly one cycle. The base then selects code 2, the ALU result held in E3. An address base never selects code 1.
- R4: A load writing r, followed at once by a load or store whose base is r, stalls two cycles, and the base selects code 0 (register file). With one unrelated instruction in between, the stall is one cycle and the select is code 0.
- R5: With one unrelated instruction between producer and consumer, there is no stall for a load feeding a late operand (code 3), for an ALU result feeding any operand (code 2), or for a load and base case that has already waited (R4). At three or more slots the select is code 0.
- R6: Instruction kinds are coded 0 for ALU, 1 for load and 2 for store. A store writes no register, and neither does any instruction whose destination is register 0. Such instructions never cause a stall or a forward. A source whose enable is low selects code 0 and causes no stall.
- R7: Every cycle in which the issue stage is stalled puts a bubble into E1: the next cycle shows `e1_valid` low and both selects at code 0.
- R8: When several in-flight instructions write the register an operand reads, only the youngest one counts, both for the stall decision and for the select.
- R9: An instruction with no dependence on any in-flight instruction, or an idle input (`in_valid` low), sees `in_ready` high and gets code 0 on every operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented for issue |
| in_ready | output | 1 | Issue may proceed this cycle; low means stall |
| in_kind | input | 2 | 0 ALU, 1 load, 2 store |
| in_dst | input | REG_W | Destination register number |
| in_src_a | input | REG_W | First source; address base for loads and stores |
| in_src_a_en | input | 1 | First source is read |
| in_src_b | input | REG_W | Second source, always a late operand |
| in_src_b_en | input | 1 | Second source is read |
| e1_valid | output | 1 | E1 holds an instruction, not a bubble |
| e1_sel_a | output | 2 | First operand select in E1: 0 register file, 1 E2 ALU, 2 E3 ALU, 3 E3 load |
| e1_sel_b | output | 2 | Second operand select in E1, same coding |

## Verification
Assertions check four rules on every cycle. A stall always produces a bubble in E1. An idle input always leaves issue ready. No instruction is accepted right behind a load it depends on. The E2 forward is chosen only when E2 holds a non-load producer, and never for an address base. The exact stall counts depend on instruction distance and operand role, and so do the chosen select codes and the youngest-producer priority when an older writer is shadowed. Only the bench can show these, through its directed sequences and a long random stream checked against a timing model of producer and consumer distance.

// File: rtl/dlyx_pkg.sv
package dlyx_pkg;
  localparam logic [1:0] KIND_ALU   = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  typedef enum logic [1:0] {
    SEL_RF      = 2'd0,
    SEL_E2_ALU  = 2'd1,
    SEL_E3_ALU  = 2'd2,
    SEL_E3_LOAD = 2'd3
  } fsel_e;
endpackage

// File: rtl/dlyx_hazard.sv
// Issue-time check for one operand against the producers in E1 and E2.
module dlyx_hazard #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             en,
  input  logic             early,
  input  logic             p1_wr,
  input  logic             p1_ld,
  input  logic [REG_W-1:0] p1_dst,
  input  logic             p2_wr,
  input  logic             p2_ld,
  input  logic [REG_W-1:0] p2_dst,
  output logic             hazard
);
  logic m1, m2;

  assign m1 = en && p1_wr && (p1_dst == src);
  assign m2 = en && p2_wr && (p2_dst == src);

  // Youngest match decides. A producer one slot ahead is late only for
  // loads, or for an address base; two slots ahead only a load feeding a base.
  always_comb begin
    if (m1)      hazard = p1_ld || early;
    else if (m2) hazard = p2_ld && early;
    else         hazard = 1'b0;
  end
endmodule

// File: rtl/dlyx_fwd_sel.sv
// E1 operand source select for one operand.
module dlyx_fwd_sel
  import dlyx_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             en,
  input  logic             p2_wr,
  input  logic [REG_W-1:0] p2_dst,
  input  logic             p3_wr,
  input  logic             p3_ld,
  input  logic [REG_W-1:0] p3_dst,
  output logic [1:0]       sel
);
  logic m2, m3;

  assign m2 = en && p2_wr && (p2_dst == src);
  assign m3 = en && p3_wr && (p3_dst == src);

  always_comb begin
    if (m2)      sel = SEL_E2_ALU;
    else if (m3) sel = p3_ld ? SEL_E3_LOAD : SEL_E3_ALU;
    else         sel = SEL_RF;
  end
endmodule

// File: rtl/dlyx_interlock.sv
module dlyx_interlock
  import dlyx_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src_a,
  input  logic             in_src_a_en,
  input  logic [REG_W-1:0] in_src_b,
  input  logic             in_src_b_en,
  output logic             e1_valid,
  output logic [1:0]       e1_sel_a,
  output logic [1:0]       e1_sel_b
);
  localparam int NOPS = 2;  // operand 0 is the address base of memory ops
  localparam int NST  = 3;  // tracked stages: index 0 = E1, 1 = E2, 2 = E3

  logic id_load, id_mem, id_wr, accept;
  logic [NOPS-1:0][REG_W-1:0] id_src;
  logic [NOPS-1:0]            id_en, id_early;

  assign id_load  = (in_kind == KIND_LOAD);
  assign id_mem   = (in_kind == KIND_LOAD) || (in_kind == KIND_STORE);
  assign id_wr    = (in_kind != KIND_STORE) && (in_dst != '0);
  assign id_src   = {in_src_b, in_src_a};
  assign id_en    = {in_src_b_en, in_src_a_en} & {NOPS{in_valid}};
  assign id_early = {1'b0, id_mem};

  // producer tags per stage
  logic [NST-1:0]            st_wr, st_ld;
  logic [NST-1:0][REG_W-1:0] st_dst;
  // consumer tags held in E1
  logic [NOPS-1:0][REG_W-1:0] e1_src;
  logic [NOPS-1:0]            e1_en, e1_early;

  logic [NOPS-1:0]      op_haz;
  logic [NOPS-1:0][1:0] op_sel;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    dlyx_hazard #(.REG_W(REG_W)) u_haz (
      .src(id_src[g]), .en(id_en[g]), .early(id_early[g]),
      .p1_wr(st_wr[0]), .p1_ld(st_ld[0]), .p1_dst(st_dst[0]),
      .p2_wr(st_wr[1]), .p2_ld(st_ld[1]), .p2_dst(st_dst[1]),
      .hazard(op_haz[g])
    );
    dlyx_fwd_sel #(.REG_W(REG_W)) u_sel (
      .src(e1_src[g]), .en(e1_en[g]),
      .p2_wr(st_wr[1]), .p2_dst(st_dst[1]),
      .p3_wr(st_wr[2]), .p3_ld(st_ld[2]), .p3_dst(st_dst[2]),
      .sel(op_sel[g])
    );
  end

  assign in_ready = ~|op_haz;
  assign accept   = in_valid && in_ready;
  assign e1_sel_a = op_sel[0];
  assign e1_sel_b = op_sel[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_wr    <= '0;
      st_ld    <= '0;
      st_dst   <= '0;
      e1_valid <= 1'b0;
      e1_src   <= '0;
      e1_en    <= '0;
      e1_early <= '0;
    end else begin
      // a stalled cycle loads a bubble into E1
      st_wr[0]  <= accept && id_wr;
      st_ld[0]  <= accept && id_load;
      st_dst[0] <= in_dst;
      e1_valid  <= accept;
      e1_src    <= id_src;
      e1_en     <= accept ? id_en : '0;
      e1_early  <= id_early;
      for (int s = 1; s < NST; s++) begin
        st_wr[s]  <= st_wr[s-1];
        st_ld[s]  <= st_ld[s-1];
        st_dst[s] <= st_dst[s-1];
      end
    end
  end

  // R7: a stalled issue cycle is followed by a bubble in E1
  assert_bubble_after_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (!e1_valid && e1_sel_a == SEL_RF && e1_sel_b == SEL_RF));

  // R9: an idle input never reports a stall
  assert_idle_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> in_ready);

  // R1: nothing that reads a load's target enters right behind that load
  assert_load_use_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && $past(accept && id_load && id_wr) &&
      ((in_src_a_en && in_src_a == $past(in_dst)) ||
       (in_src_b_en && in_src_b == $past(in_dst)))));

  // R2: the E2 forward only ever carries an ALU result
  assert_e2_fwd_alu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_sel_a == SEL_E2_ALU || e1_sel_b == SEL_E2_ALU) |-> (st_wr[1] && !st_ld[1]));

  // R3: an address base is never fed from the E2 forward
  assert_base_not_e2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_valid && e1_early[0]) |-> (e1_sel_a != SEL_E2_ALU));
endmodule

// File: tb/dlyx_interlock_test.sv
`timescale 1ns/1ps
module dlyx_interlock_test;
  localparam int RW = 5;
  localparam int FAR = -1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_kind = 2'd0;
  logic [RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic          in_src_a_en = 1'b0, in_src_b_en = 1'b0;
  logic          e1_valid;
  logic [1:0]    e1_sel_a, e1_sel_b;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lw_edge [32];
  bit lw_ld   [32];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  dlyx_interlock #(.REG_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_dst(in_dst),
    .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
    .in_src_b(in_src_b), .in_src_b_en(in_src_b_en),
    .e1_valid(e1_valid), .e1_sel_a(e1_sel_a), .e1_sel_b(e1_sel_b)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // earliest consumer edge allowed by one source (R1..R5, R8: youngest writer)
  function automatic int need_edge(input int r, input bit en, input bit early);
    if (!en || r == 0 || lw_edge[r] <= FAR) return FAR;
    if (lw_ld[r]) return lw_edge[r] + (early ? 3 : 2);
    return lw_edge[r] + (early ? 2 : 1);
  endfunction

  // expected select for a source once the consumer enters E1 at edge c
  function automatic int exp_sel(input int r, input bit en, input int c);
    int d;
    if (!en || r == 0 || lw_edge[r] <= FAR) return 0;
    d = c - lw_edge[r];
    if (lw_ld[r]) return (d == 2) ? 3 : 0;
    if (d == 1) return 1;
    if (d == 2) return 2;
    return 0;
  endfunction

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic issue(input int kind, input int dst, input int sa, input bit ea,
                       input int sb, input bit eb, input string req);
    int first, c, stalls, ea_s, eb_s;
    bit early;
    early = (kind != 0);
    first = cyc + 1;
    c = first;
    if (need_edge(sa, ea, early) > c) c = need_edge(sa, ea, early);
    if (need_edge(sb, eb, 1'b0) > c) c = need_edge(sb, eb, 1'b0);
    ea_s = exp_sel(sa, ea, c);
    eb_s = exp_sel(sb, eb, c);
    in_valid = 1'b1; in_kind = 2'(kind); in_dst = RW'(dst);
    in_src_a = RW'(sa); in_src_a_en = ea; in_src_b = RW'(sb); in_src_b_en = eb;
    stalls = 0;
    #1;
    while (!in_ready && stalls < 10) begin
      @(negedge clk);
      stalls++;
      chk(!e1_valid && e1_sel_a == 0 && e1_sel_b == 0, "R7", "bubble in E1",
          int'(e1_valid), 0);
      #1;
    end
    @(negedge clk);
    chk(stalls == c - first, req, "stall cycles", stalls, c - first);
    chk(e1_valid, req, "E1 valid after accept", int'(e1_valid), 1);
    chk(int'(e1_sel_a) == ea_s, req, "select A", int'(e1_sel_a), ea_s);
    chk(int'(e1_sel_b) == eb_s, req, "select B", int'(e1_sel_b), eb_s);
    if (kind != 2 && dst != 0) begin
      lw_edge[dst] = c;
      lw_ld[dst] = (kind == 1);
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin lw_edge[i] = FAR; lw_ld[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!e1_valid, "R7", "reset E1 empty", int'(e1_valid), 0);
    chk(in_ready, "R9", "idle ready", int'(in_ready), 1);

    // R1: load then ALU reading it
    issue(1, 1, 0, 0, 0, 0, "R1");
    issue(0, 2, 1, 1, 0, 0, "R1");
    idle(4);
    issue(1, 1, 0, 0, 0, 0, "R1");
    issue(2, 0, 7, 1, 1, 1, "R1");  // store data operand is late
    idle(4);
    // R2: ALU to ALU
    issue(0, 3, 0, 0, 0, 0, "R2");
    issue(0, 4, 0, 0, 3, 1, "R2");
    idle(4);
    // R3: ALU to address base
    issue(0, 4, 0, 0, 0, 0, "R3");
    issue(1, 5, 4, 1, 0, 0, "R3");
    issue(0, 6, 0, 0, 0, 0, "R3");
    issue(2, 0, 6, 1, 0, 0, "R3");
    idle(4);
    // R4: load to address base, adjacent and one apart
    issue(1, 6, 0, 0, 0, 0, "R4");
    issue(1, 7, 6, 1, 0, 0, "R4");
    issue(1, 8, 0, 0, 0, 0, "R4");
    issue(0, 9, 0, 0, 0, 0, "R4");
    issue(2, 0, 8, 1, 0, 0, "R4");
    idle(4);
    // R5: one unrelated instruction between
    issue(1, 1, 0, 0, 0, 0, "R5");
    issue(0, 2, 7, 1, 7, 1, "R5");
    issue(0, 3, 1, 1, 0, 0, "R5");
    issue(0, 10, 0, 0, 0, 0, "R5");
    issue(0, 11, 0, 0, 0, 0, "R5");
    issue(2, 0, 10, 1, 0, 0, "R5");
    idle(4);
    // R6: register 0, store, disabled source
    issue(0, 0, 0, 0, 0, 0, "R6");
    issue(0, 5, 0, 1, 0, 1, "R6");
    issue(2, 12, 0, 0, 0, 0, "R6");
    issue(0, 13, 12, 1, 12, 1, "R6");
    issue(1, 14, 0, 0, 0, 0, "R6");
    issue(0, 15, 14, 0, 14, 0, "R6");
    idle(4);
    // R8: youngest producer wins
    issue(0, 1, 0, 0, 0, 0, "R8");
    issue(0, 1, 0, 0, 0, 0, "R8");
    issue(0, 2, 1, 1, 0, 0, "R8");
    idle(4);
    issue(1, 1, 0, 0, 0, 0, "R8");
    issue(0, 1, 0, 0, 0, 0, "R8");
    issue(0, 2, 0, 0, 1, 1, "R8");
    idle(4);
    // R9: independent work
    issue(0, 5, 6, 1, 7, 1, "R9");
    issue(1, 16, 17, 1, 0, 0, "R9");
    idle(1);
    chk(in_ready, "R9", "idle ready", int'(in_ready), 1);

    // random stream over a small register set
    void'($urandom(32'd24681));
    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom_range(2, 0));
      issue(k, int'($urandom_range(5, 0)), int'($urandom_range(5, 0)),
            1'($urandom_range(1, 0)), int'($urandom_range(5, 0)),
            1'($urandom_range(1, 0)), "R8");
      if ($urandom_range(7, 0) == 0) idle(int'($urandom_range(2, 1)));
    end
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule